// File: doc/BRIEF.md
# Self-Correcting Six-State JK Counter

This block is a three-bit counter made of three JK flip-flops that share one rising clock edge. It steps through six of the eight three-bit codes in a fixed order that is not binary. The two codes it never visits are still covered by the same excitation equations, so each of them rejoins the loop after a single clock. The counter therefore cannot lock up, whatever state it powers up in.

The output is the three flip-flop values, with flop A in the most significant position, then B, then C. A synchronous reset returns the counter to code 000. A test-only preload port writes any of the eight codes directly into the flip-flops. This lets a bench reach the unused codes, which normal counting never produces.

Top module: `mod6_jk_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 000 on that edge, whatever `load_en` and the current state are. It stays 000 for as long as `rst` remains high.
- R2: With `rst` and `load_en` low, each rising edge moves `count` (bit 2 = A, bit 1 = B, bit 0 = C) along the loop 000, 001, 010, 100, 101, 110, and from 110 back to 000.
- R3: Starting from 000, `count` first returns to 000 after exactly six edges, and it visits six distinct codes on the way.
- R4: From the unused code 011, the next edge gives 100.
- R5: From the unused code 111, the next edge gives 000.
- R6: With `rst` low and `load_en` high, the next edge places `load_code` on `count`. This overrides normal stepping and works for all eight codes.
- R7: With `rst` and `load_en` low, `count` changes on every edge. From any of the eight codes it reaches 000 within six edges, so no lock-up loop exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all three flip-flops |
| rst | input | 1 | Synchronous active-high reset to 000 |
| load_en | input | 1 | Test-only preload enable |
| load_code | input | 3 | Code written when `load_en` is high (bit 2 = A) |
| count | output | 3 | Counter state: bit 2 = A, bit 1 = B, bit 0 = C |

## Verification
The bench preloads every one of the eight codes and takes one step from each, comparing the result with the successor table. This separates faults in each flip-flop's J/K inputs, because each input affects only certain source codes, and it also covers the two recovery paths. A free run from 000 checks the order of the loop and its length of six. Walks from every code down to 000 check the lock-up bound. Preload requests made while reset is high check that reset has priority.

// File: rtl/mod6_pkg.sv
package mod6_pkg;

    localparam int FF_COUNT = 3;
    localparam int IDX_A    = 2;
    localparam int IDX_B    = 1;
    localparam int IDX_C    = 0;

    localparam logic [FF_COUNT-1:0] RESET_CODE = '0;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } ctr_state_t;

    typedef struct packed {
        logic j;
        logic k;
    } jk_drive_t;

    // JK rule: hold, clear, set, toggle
    function automatic logic jk_apply(input logic q, input jk_drive_t d);
        logic nq;
        unique case ({d.j, d.k})
            2'b00:   nq = q;
            2'b01:   nq = 1'b0;
            2'b10:   nq = 1'b1;
            default: nq = ~q;
        endcase
        return nq;
    endfunction

endpackage

// File: rtl/mod6_excite.sv
module mod6_excite
    import mod6_pkg::*;
(
    input  ctr_state_t cur,
    output jk_drive_t  drv [FF_COUNT]
);
    always_comb begin
        // flop A: both inputs follow B
        drv[IDX_A].j = cur.b;
        drv[IDX_A].k = cur.b;
        // flop B: set from C, always clear-capable
        drv[IDX_B].j = cur.c;
        drv[IDX_B].k = 1'b1;
        // flop C: set when B is low, always clear-capable
        drv[IDX_C].j = ~cur.b;
        drv[IDX_C].k = 1'b1;
    end
endmodule

// File: rtl/jk_cell.sv
module jk_cell
    import mod6_pkg::*;
#(
    parameter logic INIT = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pre_en,
    input  logic      pre_val,
    input  jk_drive_t drv,
    output logic      q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= INIT;
        else if (pre_en)
            q <= pre_val;
        else
            q <= jk_apply(q, drv);
    end
endmodule

// File: rtl/mod6_jk_counter.sv
module mod6_jk_counter
    import mod6_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  logic [2:0] load_code,
    output logic [2:0] count
);
    ctr_state_t cur;
    jk_drive_t  drv [FF_COUNT];
    logic [FF_COUNT-1:0] q_bits;

    assign cur   = ctr_state_t'(q_bits);
    assign count = q_bits;

    mod6_excite u_excite (
        .cur (cur),
        .drv (drv)
    );

    for (genvar i = 0; i < FF_COUNT; i++) begin : g_ff
        jk_cell #(
            .INIT (RESET_CODE[i])
        ) u_ff (
            .clk     (clk),
            .rst     (rst),
            .pre_en  (load_en),
            .pre_val (load_code[i]),
            .drv     (drv[i]),
            .q       (q_bits[i])
        );
    end
endmodule

// File: rtl/mod6_jk_counter_chk.sv
module mod6_jk_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_en,
    input logic [2:0] load_code,
    input logic [2:0] count
);
    function automatic logic [2:0] succ(input logic [2:0] s);
        case (s)
            3'b000:  return 3'b001;
            3'b001:  return 3'b010;
            3'b010:  return 3'b100;
            3'b100:  return 3'b101;
            3'b101:  return 3'b110;
            3'b110:  return 3'b000;
            3'b011:  return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> count == 3'b000);

    p_loop_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count != 3'b011 && count != 3'b111) |=> count == succ($past(count)));

    p_recover_011_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count == 3'b011) |=> count == 3'b100);

    p_recover_111_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_en && count == 3'b111) |=> count == 3'b000);

    p_preload_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count == $past(load_code));

    p_always_moves_r7: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> count != $past(count));
endmodule

bind mod6_jk_counter mod6_jk_counter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_code (load_code),
    .count     (count)
);

// File: tb/mod6_jk_counter_bench.sv
module mod6_jk_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [2:0] load_code = 3'b000;
    logic [2:0] count;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mod6_jk_counter u_mod6_jk_counter (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_code (load_code),
        .count     (count)
    );

    // successor table written from the requirements
    function automatic logic [2:0] expect_next(input logic [2:0] s);
        case (s)
            3'b000:  return 3'b001;
            3'b001:  return 3'b010;
            3'b010:  return 3'b100;
            3'b011:  return 3'b100;
            3'b100:  return 3'b101;
            3'b101:  return 3'b110;
            3'b110:  return 3'b000;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [2:0] code);
        @(negedge clk);
        load_en   = 1'b1;
        load_code = code;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        logic [2:0] prev;
        // R1: reset state and hold under reset, even with preload requested
        repeat (2) @(negedge clk);
        chk("R1 reset value", count, 3'b000);
        load_en = 1'b1;
        load_code = 3'b101;
        repeat (3) @(negedge clk);
        chk("R1 reset overrides preload", count, 3'b000);
        load_en = 1'b0;
        rst = 1'b0;

        // R2, R3: free run from 000
        step();
        chk("R2 first step", count, 3'b001);
        begin
            logic [2:0] s;
            s = 3'b001;
            for (int n = 2; n <= 6; n++) begin
                step();
                s = expect_next(s);
                chk(n == 6 ? "R3 back to 000 after six" : "R2 loop order", count, s);
                if (n < 6 && count === 3'b000)
                    chk("R3 early return to 000", count, 3'b111);
            end
        end

        // R6 preload all codes, then R2/R4/R5/R7 single step
        for (int v = 0; v < 8; v++) begin
            preload(3'(v));
            chk("R6 preload value", count, 3'(v));
            prev = count;
            step();
            if (v == 3)
                chk("R4 recover from 011", count, 3'b100);
            else if (v == 7)
                chk("R5 recover from 111", count, 3'b000);
            else
                chk("R2 successor", count, expect_next(3'(v)));
            if (count === prev)
                chk("R7 state must change", count, expect_next(prev));
        end

        // R7: lock-up bound from every code
        for (int v = 0; v < 8; v++) begin
            int steps;
            preload(3'(v));
            steps = 0;
            do begin
                step();
                steps++;
            end while (count !== 3'b000 && steps < 8);
            total++;
            if (steps > 6) begin
                bad++;
                $display("FAIL R7 from %0d actual=%0d steps expected<=6", v, steps);
            end
        end

        // R6: preload mid-run overrides counting
        preload(3'b110);
        step();
        preload(3'b011);
        chk("R6 preload mid-run", count, 3'b011);

        // R1: reset mid-run
        step();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-run", count, 3'b000);
        rst = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule